// File: doc/BRIEF.md
# Two-Digit Decimal Counter with Seven-Segment Outputs

This block is a decimal counter that runs from 00 to 99. It is built from two synchronous digit stages, one for units and one for tens. Each stage counts only through the values 0 to 9. The units stage passes a carry to the tens stage when it reaches 9, so the pair behaves as one two-digit counter that wraps from 99 back to 00.

Both digits can be preset in the same clock edge from two 4-bit load values. A load value that is not a valid decimal digit is clamped to 9. Each digit drives its own combinational seven-segment decoder, so a panel can be wired straight to the outputs. A terminal-count flag marks the enabled cycle in which the count is about to wrap, which lets several blocks be chained.

Top module: `bcd2_counter_display`

## Requirements
- R1: When `rst` is high on a rising clock edge, both digits become 0. After that edge, `tc_all` is 0 while the count is 00.
- R2: `units_q` and `tens_q` never hold a value above 9.
- R3: When `cnt_en` is high and `load_stb` is low, each edge adds one to the units digit. A units value of 9 wraps to 0.
- R4: The tens digit adds one only on an enabled edge where the units digit reads 9, and holds on every other edge. A tens value of 9 wraps to 0, so 99 is followed by 00.
- R5: When `cnt_en` is low and `load_stb` is low, both digits keep their values.
- R6: When `load_stb` is high on an edge, `units_q` takes `load_units` and `tens_q` takes `load_tens`. This happens whatever the state of `cnt_en`.
- R7: A load value from 10 to 15 is stored as 9.
- R8: `tc_all` is high exactly when the count reads 99 and `cnt_en` is high. It is combinational, so it follows `cnt_en` in the same cycle.
- R9: The segment outputs are active-high, with bit 0 driving segment a up through bit 6 driving segment g. The digits light these segments:
  - 0: a b c d e f
  - 1: b c
  - 2: a b d e g
  - 3: a b c d g
  - 4: b c f g
  - 5: a c d f g
  - 6: a c d e f g
  - 7: a b c
  - 8: all seven
  - 9: a b c d f g
- R10: `rst` takes priority over `load_stb` and `cnt_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| load_stb | input | 1 | Parallel load strobe; takes priority over counting |
| load_units | input | 4 | Value loaded into the units digit |
| load_tens | input | 4 | Value loaded into the tens digit |
| units_q | output | 4 | Units digit, in BCD |
| tens_q | output | 4 | Tens digit, in BCD |
| tc_all | output | 1 | High when the count is 99 and counting is enabled |
| seg_units | output | 7 | Segment pattern for the units digit, bit 0 = a |
| seg_tens | output | 7 | Segment pattern for the tens digit, bit 0 = a |

## Verification
A corrupted units register shows on `units_q` and `seg_units` in the cycle right after the bad edge. A corrupted carry only shows when the units digit passes 9, so it can take up to ten enabled cycles to appear on `tens_q`. A wrong wrap or a missed clamp would put a value above 9 on a digit port, and the segment outputs for that digit would go dark. A faulty terminal-count term shows on `tc_all` in the same cycle that `cnt_en` rises at 99.

// File: rtl/bcd2_pkg.sv
package bcd2_pkg;
  localparam int BCD_W   = 4;
  localparam int BCD_MAX = 9;
  localparam int SEG_W   = 7;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Any code above the largest decimal digit saturates to it.
  function automatic bcd_t clamp_bcd(input bcd_t v);
    return (v > bcd_t'(BCD_MAX)) ? bcd_t'(BCD_MAX) : v;
  endfunction

  // Decimal successor; the largest digit rolls over to zero.
  function automatic bcd_t inc_bcd(input bcd_t v);
    return (v >= bcd_t'(BCD_MAX)) ? '0 : v + bcd_t'(1);
  endfunction

  // Segment pattern, bit 0 = segment a ... bit 6 = segment g, active-high.
  function automatic seg_t seg_glyph(input bcd_t v);
    seg_t s;
    case (v)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd2_pkg::*;
#(
  parameter int DW = BCD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          adv,
  output logic [DW-1:0] q,
  output logic          tc
);
  logic [DW-1:0] q_r;
  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load)     q_nxt = clamp_bcd(load_val);
    else if (adv) q_nxt = inc_bcd(q_r);
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= q_nxt;
  end

  assign q  = q_r;
  assign tc = (q_r == DW'(BCD_MAX));
endmodule

// File: rtl/seg7_decoder.sv
module seg7_decoder
  import bcd2_pkg::*;
#(
  parameter int DW = BCD_W,
  parameter int SW = SEG_W
) (
  input  logic [DW-1:0] digit,
  output logic [SW-1:0] seg
);
  assign seg = seg_glyph(digit);
endmodule

// File: rtl/bcd2_counter_display.sv
module bcd2_counter_display
  import bcd2_pkg::*;
#(
  parameter int DW = BCD_W,
  parameter int SW = SEG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          load_stb,
  input  logic [DW-1:0] load_units,
  input  logic [DW-1:0] load_tens,
  output logic [DW-1:0] units_q,
  output logic [DW-1:0] tens_q,
  output logic          tc_all,
  output logic [SW-1:0] seg_units,
  output logic [SW-1:0] seg_tens
);
  localparam int ND = 2;

  logic [ND-1:0][DW-1:0] ld_vals;
  logic [ND-1:0][DW-1:0] digit_q;
  logic [ND-1:0][SW-1:0] digit_seg;
  logic [ND-1:0]         digit_tc;
  logic [ND:0]           digit_adv;

  assign ld_vals[0]   = load_units;
  assign ld_vals[1]   = load_tens;
  assign digit_adv[0] = cnt_en;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    bcd_digit_stage #(.DW(DW)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .load     (load_stb),
      .load_val (ld_vals[i]),
      .adv      (digit_adv[i]),
      .q        (digit_q[i]),
      .tc       (digit_tc[i])
    );
    assign digit_adv[i+1] = digit_adv[i] & digit_tc[i];
    seg7_decoder #(.DW(DW), .SW(SW)) u_seg (
      .digit (digit_q[i]),
      .seg   (digit_seg[i])
    );
  end

  assign units_q   = digit_q[0];
  assign tens_q    = digit_q[1];
  assign seg_units = digit_seg[0];
  assign seg_tens  = digit_seg[1];
  assign tc_all    = digit_adv[ND];
endmodule

// File: rtl/bcd2_counter_display_checker.sv
module bcd2_counter_display_checker (
  input logic       clk,
  input logic       rst,
  input logic       cnt_en,
  input logic       load_stb,
  input logic [3:0] load_units,
  input logic [3:0] load_tens,
  input logic [3:0] units_q,
  input logic [3:0] tens_q,
  input logic       tc_all,
  input logic [6:0] seg_units,
  input logic [6:0] seg_tens,
  input logic [1:0] digit_tc
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (units_q == 4'd0 && tens_q == 4'd0 && !tc_all));

  a_r2_digit_range: assert property (@(posedge clk) disable iff (rst)
    (units_q <= 4'd9) && (tens_q <= 4'd9));

  a_r3_units_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !load_stb) |=>
      (units_q == (($past(units_q) == 4'd9) ? 4'd0 : $past(units_q) + 4'd1)));

  a_r4_tens_holds: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !(cnt_en && digit_tc[0])) |=> $stable(tens_q));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !cnt_en) |=> ($stable(units_q) && $stable(tens_q)));

  a_r6_load_takes: assert property (@(posedge clk) disable iff (rst)
    (load_stb && load_units <= 4'd9 && load_tens <= 4'd9) |=>
      (units_q == $past(load_units) && tens_q == $past(load_tens)));

  a_r7_load_clamps: assert property (@(posedge clk) disable iff (rst)
    (load_stb && load_units > 4'd9) |=> (units_q == 4'd9));

  a_r8_wrap_after_tc: assert property (@(posedge clk) disable iff (rst)
    (tc_all && !load_stb) |=> (units_q == 4'd0 && tens_q == 4'd0));

  a_r9_segments_lit: assert property (@(posedge clk) disable iff (rst)
    (seg_units != 7'd0) && (seg_tens != 7'd0));
endmodule

bind bcd2_counter_display bcd2_counter_display_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_en     (cnt_en),
  .load_stb   (load_stb),
  .load_units (load_units),
  .load_tens  (load_tens),
  .units_q    (units_q),
  .tens_q     (tens_q),
  .tc_all     (tc_all),
  .seg_units  (seg_units),
  .seg_tens   (seg_tens),
  .digit_tc   (digit_tc)
);

// File: tb/bcd2_counter_display_test.sv
`timescale 1ns/1ps
module bcd2_counter_display_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       load_stb = 1'b0;
  logic [3:0] load_units = '0;
  logic [3:0] load_tens = '0;
  logic [3:0] units_q, tens_q;
  logic       tc_all;
  logic [6:0] seg_units, seg_tens;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_u    = 0;
  int exp_t    = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bcd2_counter_display uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_stb(load_stb),
    .load_units(load_units), .load_tens(load_tens),
    .units_q(units_q), .tens_q(tens_q), .tc_all(tc_all),
    .seg_units(seg_units), .seg_tens(seg_tens)
  );

  // Glyph rebuilt segment by segment from the lit-segment list of R9.
  function automatic logic [6:0] glyph(input int d);
    logic [6:0] s;
    s[0] = !(d == 1 || d == 4);
    s[1] = !(d == 5 || d == 6);
    s[2] = (d != 2);
    s[3] = !(d == 1 || d == 4 || d == 7);
    s[4] = (d == 0 || d == 2 || d == 6 || d == 8);
    s[5] = !(d == 1 || d == 2 || d == 3 || d == 7);
    s[6] = !(d == 0 || d == 1 || d == 7);
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_count(input string req);
    check(req, int'(units_q), exp_u);
    check(req, int'(tens_q), exp_t);
  endtask

  // One clock edge with the given inputs; the bench's own model follows.
  task automatic step(input bit r, input bit ld, input bit en,
                      input int lu, input int lt);
    rst = r; load_stb = ld; cnt_en = en;
    load_units = 4'(lu); load_tens = 4'(lt);
    @(posedge clk);
    if (r) begin
      exp_u = 0; exp_t = 0;
    end else if (ld) begin
      exp_u = (lu > 9) ? 9 : lu;
      exp_t = (lt > 9) ? 9 : lt;
    end else if (en) begin
      if (exp_u == 9) begin
        exp_u = 0;
        exp_t = (exp_t == 9) ? 0 : exp_t + 1;
      end else begin
        exp_u = exp_u + 1;
      end
    end
    #1;
  endtask

  task automatic t_reset();
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    check_count("R1");
    check("R1", int'(tc_all), 0);
  endtask

  task automatic t_units_count();
    for (int k = 0; k < 12; k++) begin
      step(0, 0, 1, 0, 0);
      check_count("R3");
    end
  endtask

  task automatic t_carry();
    step(0, 1, 0, 7, 3);
    check_count("R6");
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 1, 0, 0);
      check_count("R4");
    end
    check("R4", int'(tens_q), 4);
  endtask

  task automatic t_hold();
    step(0, 1, 0, 9, 5);
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 3, 3);
      check_count("R5");
    end
  endtask

  task automatic t_load_priority();
    step(0, 1, 1, 2, 6);
    check_count("R6");
    check("R6", int'(units_q), 2);
  endtask

  task automatic t_clamp();
    step(0, 1, 0, 15, 12);
    check_count("R7");
    check("R7", int'(units_q), 9);
    step(0, 1, 0, 10, 4);
    check_count("R7");
  endtask

  task automatic t_wrap();
    step(0, 1, 0, 8, 9);
    check("R8", int'(tc_all), 0);
    step(0, 0, 1, 0, 0);
    check_count("R4");
    #1;
    check("R8", int'(tc_all), 1);
    cnt_en = 1'b0;
    #1;
    check("R8", int'(tc_all), 0);
    cnt_en = 1'b1;
    step(0, 0, 1, 0, 0);
    check("R4", int'(units_q), 0);
    check("R4", int'(tens_q), 0);
    check("R8", int'(tc_all), 0);
  endtask

  task automatic t_segments();
    for (int d = 0; d < 10; d++) begin
      step(0, 1, 0, d, 9 - d);
      check("R9", int'(seg_units), int'(glyph(d)));
      check("R9", int'(seg_tens), int'(glyph(9 - d)));
      check("R2", int'(units_q <= 4'd9), 1);
    end
  endtask

  task automatic t_reset_priority();
    step(0, 1, 0, 5, 5);
    step(1, 1, 1, 7, 7);
    check_count("R10");
    check("R10", int'(units_q), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #5;
    t_reset();
    t_units_count();
    t_carry();
    t_hold();
    t_load_priority();
    t_clamp();
    t_wrap();
    t_segments();
    t_reset_priority();
    finish_run();
  end

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule